// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Controller

This block watches a word of general-purpose input lines and raises one interrupt line when any unmasked input has a pending event. Each line is configured on its own. It is either edge-sensitive, latching a rising edge, a falling edge or any change, or level-sensitive, reporting the active-high or active-low state of the pin for as long as it lasts. Every input is first brought into the system clock domain by a flop-chain synchroniser. Edges are found by comparing each synchronised sample with the one taken on the clock before.

Software programs the controller through a simple register port. A write strobe with an address and data updates a register on the clock edge. A combinational read port returns one register selected by its own address. There are four configuration words: mode, dual-edge, polarity and enable. A clear word acknowledges latched edges: a bit clears its line's edge status when it goes from 0 to 1, so software writes 0 and then 1. Two read-only words report raw status and enabled (masked) status. The interrupt output is high whenever any masked status bit is set.

Top module: `pin_event_irq`

## Requirements
- R1: Reset (rst_n low at a clock edge) sets mode, dual-edge, polarity, enable and clear words and all latched edge status to 0. irq_o is then low, masked status reads 0, and raw status reads all ones, because level-low mode with low inputs is active.
- R2: Register offsets: 0 mode (1 = edge, 0 = level), 1 dual-edge, 2 polarity, 3 enable, 4 clear, 5 raw status, 6 masked status. Offsets 0 to 4 read back what was last written. Offset 7 reads 0.
- R3: In edge mode with dual-edge 0, a line's status latches a rising edge when polarity is 1 and a falling edge when polarity is 0. The opposite edge leaves it unchanged.
- R4: In edge mode with dual-edge 1, a line latches on both rising and falling edges, whatever its polarity bit.
- R5: In level mode, raw status equals the synchronised input when polarity is 1 and its inverse when polarity is 0. The dual-edge bit has no effect, and the status drops as soon as the level goes inactive.
- R6: A latched edge status bit clears only when a write to offset 4 takes that bit from 0 to 1. Writing 1 over a 1, or writing 0, leaves the status set.
- R7: If a clearing write meets a new edge on the same clock, the edge is kept when the status was 0 before. The status ends at 0 when it was already 1.
- R8: Masked status equals raw status AND enable. Edges on disabled lines are still recorded in raw status. irq_o is the OR of all masked status bits.
- R9: An input change shows in level status after two rising clock edges and in latched edge status after three.
- R10: Writes to offsets 5, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | LINES | Asynchronous GPIO input lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write offset |
| wr_data_i | input | LINES | Register write data |
| rd_addr_i | input | 3 | Register read offset |
| rd_data_o | output | LINES | Read data, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with LINES = 32 and SYNC_STAGES = 2. Stimulus patterns are 4-bit nibbles copied across all 32 bits, so every bit position and the whole width of the read mux are exercised, and each mode, polarity and mask mix lands on several lines at once. With two synchroniser stages the two- and three-edge latencies are short enough to check clock by clock. That same short latency makes it possible to line up a clearing write exactly with a freshly detected edge, in both the already-latched and the not-yet-latched cases.

// File: rtl/pei_pkg.sv
`timescale 1ns/1ps
// pei_pkg: shared definitions for the pin event interrupt controller.
// Holds the register offset map and the register port address width.
package pei_pkg;

    localparam int unsigned ADDR_W = 3;

    // Register offsets. The bench and software depend on these values.
    typedef enum logic [ADDR_W-1:0] {
        REG_MODE = 3'd0,   // 1 = edge, 0 = level
        REG_DUAL = 3'd1,   // 1 = both edges (edge mode only)
        REG_POL  = 3'd2,   // 1 = rising/high, 0 = falling/low
        REG_EN   = 3'd3,   // 1 = unmasked
        REG_CLR  = 3'd4,   // 0->1 clears latched edge status
        REG_RAW  = 3'd5,   // read-only raw status
        REG_MSK  = 3'd6,   // read-only masked status
        REG_NONE = 3'd7    // reads as zero
    } pei_reg_e;

endpackage

// File: rtl/pei_sync.sv
`timescale 1ns/1ps
// pei_sync: multi-stage flop chain moving asynchronous inputs into the
// clk domain. Assumes each bit is sampled independently (no bus coherency).
module pei_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first capture flop of the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= d_i;
            end
        end else begin : g_next
            // further settling stages
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pei_regfile.sv
`timescale 1ns/1ps
// pei_regfile: configuration words, acknowledge word and read mux.
// Produces a one-cycle clear pulse for every clear bit taken from 0 to 1
// by a write. Assumes writes are single-cycle strobes; reads are
// combinational from the current state.
module pei_regfile
    import pei_pkg::*;
#(
    parameter int unsigned LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [LINES-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [LINES-1:0]  rd_data_o,
    input  logic [LINES-1:0]  raw_i,
    input  logic [LINES-1:0]  msk_i,
    output logic [LINES-1:0]  mode_o,
    output logic [LINES-1:0]  dual_o,
    output logic [LINES-1:0]  pol_o,
    output logic [LINES-1:0]  en_o,
    output logic [LINES-1:0]  clr_o,
    output logic [LINES-1:0]  clr_pulse_o
);

    logic [LINES-1:0] mode_q, dual_q, pol_q, en_q, clr_q;
    logic             hit_clr;

    assign hit_clr = wr_en_i && (pei_reg_e'(wr_addr_i) == REG_CLR);

    // configuration and acknowledge storage, updated by write strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            dual_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
            clr_q  <= '0;
        end else if (wr_en_i) begin
            case (pei_reg_e'(wr_addr_i))
                REG_MODE: mode_q <= wr_data_i;
                REG_DUAL: dual_q <= wr_data_i;
                REG_POL:  pol_q  <= wr_data_i;
                REG_EN:   en_q   <= wr_data_i;
                REG_CLR:  clr_q  <= wr_data_i;
                default:  ;
            endcase
        end
    end

    // rising transition of each clear bit, valid in the write cycle
    always_comb begin
        clr_pulse_o = hit_clr ? (wr_data_i & ~clr_q) : '0;
    end

    // read-back selection
    always_comb begin
        case (pei_reg_e'(rd_addr_i))
            REG_MODE: rd_data_o = mode_q;
            REG_DUAL: rd_data_o = dual_q;
            REG_POL:  rd_data_o = pol_q;
            REG_EN:   rd_data_o = en_q;
            REG_CLR:  rd_data_o = clr_q;
            REG_RAW:  rd_data_o = raw_i;
            REG_MSK:  rd_data_o = msk_i;
            default:  rd_data_o = '0;
        endcase
    end

    assign mode_o = mode_q;
    assign dual_o = dual_q;
    assign pol_o  = pol_q;
    assign en_o   = en_q;
    assign clr_o  = clr_q;

endmodule

// File: rtl/pei_detect.sv
`timescale 1ns/1ps
// pei_detect: per-line event detection. Edge lines compare the current
// synchronised sample with the previous one and latch qualifying edges
// until cleared; level lines report the polarity-adjusted level directly.
// Assumes sync_i is already in the clk domain.
module pei_detect #(
    parameter int unsigned LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] sync_i,
    input  logic [LINES-1:0] mode_i,
    input  logic [LINES-1:0] dual_i,
    input  logic [LINES-1:0] pol_i,
    input  logic [LINES-1:0] clr_pulse_i,
    output logic [LINES-1:0] hit_o,
    output logic [LINES-1:0] edge_stat_o,
    output logic [LINES-1:0] raw_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic prev_q;
        logic lat_q;
        logic rise, fall, hit;

        // previous synchronised sample for edge comparison
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sync_i[g];
        end

        // qualify the edge against mode, dual-edge and polarity
        always_comb begin
            rise = sync_i[g] & ~prev_q;
            fall = ~sync_i[g] & prev_q;
            if (!mode_i[g])      hit = 1'b0;
            else if (dual_i[g])  hit = rise | fall;
            else if (pol_i[g])   hit = rise;
            else                 hit = fall;
        end

        // latched edge status; a clear only wins over an edge that is
        // already recorded
        always_ff @(posedge clk) begin
            if (!rst_n)              lat_q <= 1'b0;
            else if (clr_pulse_i[g]) lat_q <= hit & ~lat_q;
            else if (hit)            lat_q <= 1'b1;
        end

        // raw status: latched edge or live level
        always_comb begin
            if (mode_i[g]) raw_o[g] = lat_q;
            else           raw_o[g] = pol_i[g] ? sync_i[g] : ~sync_i[g];
        end

        assign hit_o[g]       = hit;
        assign edge_stat_o[g] = lat_q;
    end

endmodule

// File: rtl/pin_event_irq.sv
`timescale 1ns/1ps
// pin_event_irq: GPIO interrupt controller for one word of input lines.
// Synchronises the inputs, detects per-line edge or level events,
// masks them with the enable word and ORs the result into irq_o.
// Assumes a single clock domain for the register port.
module pin_event_irq
    import pei_pkg::*;
#(
    parameter int unsigned LINES       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  line_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [LINES-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [LINES-1:0]  rd_data_o,
    output logic              irq_o
);

    logic [LINES-1:0] sync_w;
    logic [LINES-1:0] mode_w, dual_w, pol_w, en_w, clr_w, clr_pulse_w;
    logic [LINES-1:0] hit_w, edge_stat_w, raw_w, msk_w;

    pei_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_i),
        .q_o   (sync_w)
    );

    pei_regfile #(.LINES(LINES)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o),
        .raw_i       (raw_w),
        .msk_i       (msk_w),
        .mode_o      (mode_w),
        .dual_o      (dual_w),
        .pol_o       (pol_w),
        .en_o        (en_w),
        .clr_o       (clr_w),
        .clr_pulse_o (clr_pulse_w)
    );

    pei_detect #(.LINES(LINES)) u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_w),
        .mode_i      (mode_w),
        .dual_i      (dual_w),
        .pol_i       (pol_w),
        .clr_pulse_i (clr_pulse_w),
        .hit_o       (hit_w),
        .edge_stat_o (edge_stat_w),
        .raw_o       (raw_w)
    );

    // mask and combine into the single request line
    always_comb begin
        msk_w = raw_w & en_w;
        irq_o = |msk_w;
    end

endmodule

// File: rtl/pin_event_irq_chk.sv
`timescale 1ns/1ps
// pin_event_irq_chk: temporal properties of the interrupt controller,
// attached to every instance of pin_event_irq through bind.
module pin_event_irq_chk
    import pei_pkg::*;
#(
    parameter int unsigned LINES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq,
    input logic [LINES-1:0]  mode,
    input logic [LINES-1:0]  dual,
    input logic [LINES-1:0]  pol,
    input logic [LINES-1:0]  en,
    input logic [LINES-1:0]  clr,
    input logic [LINES-1:0]  clr_pulse,
    input logic [LINES-1:0]  hit,
    input logic [LINES-1:0]  edge_stat
);

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mode == '0 && dual == '0 && pol == '0 &&
                           en == '0 && clr == '0 && edge_stat == '0));

    // R3
    set_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_stat & ~$past(edge_stat) & ~$past(hit)) == '0));

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_stat & $past(clr_pulse & edge_stat)) == '0));

    // R6
    no_clear_on_held_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pei_reg_e'(wr_addr) == REG_CLR) |=>
            ((edge_stat & $past(edge_stat & clr)) == $past(edge_stat & clr)));

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

endmodule

bind pin_event_irq pin_event_irq_chk #(.LINES(LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .irq       (irq_o),
    .mode      (mode_w),
    .dual      (dual_w),
    .pol       (pol_w),
    .en        (en_w),
    .clr       (clr_w),
    .clr_pulse (clr_pulse_w),
    .hit       (hit_w),
    .edge_stat (edge_stat_w)
);

// File: tb/test_pin_event_irq.sv
`timescale 1ns/1ps
module test_pin_event_irq;

    localparam int unsigned LINES = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LINES-1:0] line = '0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [LINES-1:0] wr_data = '0;
    logic [2:0]       rd_addr = '0;
    logic [LINES-1:0] rd_data;
    logic             irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    pin_event_irq #(.LINES(LINES), .SYNC_STAGES(2)) i_pin_event_irq (
        .clk (clk), .rst_n (rst_n), .line_i (line),
        .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
        .rd_addr_i (rd_addr), .rd_data_o (rd_data), .irq_o (irq)
    );

    // nibble fields: mode, dual, pol, en, in0, in1, expected raw
    localparam logic [27:0] VEC [8] = '{
        28'hF0FF_05_5,  // R3 rising
        28'hF00F_F3_C,  // R3 falling
        28'hFF5F_63_5,  // R4 both edges, polarity ignored
        28'h0FAF_09_C,  // R5 level, dual ignored
        28'hF0F3_0F_F,  // R8 partial mask
        28'hF0F0_0F_F,  // R8 masked lines still record
        28'h50FF_06_6,  // R3 R5 mixed modes
        28'hF0FF_F0_0   // R3 opposite edge ignored
    };

    function automatic logic [31:0] rep(input logic [3:0] n);
        return {8{n}};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        line  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    logic [31:0] v;

    initial begin
        // ---------------- R1 reset state ----------------
        do_reset();
        @(negedge clk);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); chk($sformatf("R1 reg %0d", a), v, 32'h0);
        end
        rd(3'd5, v); chk("R1 raw", v, 32'hFFFF_FFFF);
        rd(3'd6, v); chk("R1 masked", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // ---------------- R2 read back, R10 read-only ----------------
        wr(3'd0, 32'h1234_5678); wr(3'd1, 32'h9ABC_DEF0);
        wr(3'd2, 32'h0F0F_0F0F); wr(3'd4, 32'hA5A5_A5A5);
        rd(3'd0, v); chk("R2 mode", v, 32'h1234_5678);
        rd(3'd1, v); chk("R2 dual", v, 32'h9ABC_DEF0);
        rd(3'd2, v); chk("R2 pol", v, 32'h0F0F_0F0F);
        rd(3'd4, v); chk("R2 clr", v, 32'hA5A5_A5A5);
        rd(3'd7, v); chk("R2 offset7", v, 32'h0);
        do_reset();
        wr(3'd5, 32'h0); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); chk($sformatf("R10 reg %0d", a), v, 32'h0);
        end
        rd(3'd5, v); chk("R10 raw", v, 32'hFFFF_FFFF);
        rd(3'd6, v); chk("R10 masked", v, 32'h0);

        // ---------------- vector table ----------------
        for (int i = 0; i < 8; i++) begin
            logic [31:0] m, du, p, e, i0, i1, ex;
            m  = rep(VEC[i][27:24]); du = rep(VEC[i][23:20]);
            p  = rep(VEC[i][19:16]); e  = rep(VEC[i][15:12]);
            i0 = rep(VEC[i][11:8]);  i1 = rep(VEC[i][7:4]);
            ex = rep(VEC[i][3:0]);
            do_reset();
            wr(3'd0, m); wr(3'd1, du); wr(3'd2, p); wr(3'd3, e);
            line = i0;
            settle();
            wr(3'd4, 32'h0); wr(3'd4, 32'hFFFF_FFFF);
            line = i1;
            settle();
            rd(3'd5, v); chk($sformatf("R3 R4 R5 vec%0d raw", i), v, ex);
            rd(3'd6, v); chk($sformatf("R8 vec%0d masked", i), v, ex & e);
            chk($sformatf("R8 vec%0d irq", i), {31'b0, irq}, {31'b0, |(ex & e)});
        end

        // ---------------- R5 level not latched ----------------
        do_reset();
        wr(3'd2, 32'hFFFF_FFFF);
        line = 32'h1; settle();
        rd(3'd5, v); chk("R5 level high", v, 32'h1);
        line = 32'h0; settle();
        rd(3'd5, v); chk("R5 level drops", v, 32'h0);

        // ---------------- R9 latency ----------------
        do_reset();
        wr(3'd2, 32'hFFFF_FFFF);
        line = 32'h1;
        @(negedge clk); rd(3'd5, v); chk("R9 level after 1 edge", v, 32'h0);
        @(negedge clk); rd(3'd5, v); chk("R9 level after 2 edges", v, 32'h1);
        do_reset();
        wr(3'd0, 32'hFFFF_FFFF); wr(3'd2, 32'hFFFF_FFFF);
        line = 32'h1;
        @(negedge clk);
        @(negedge clk); rd(3'd5, v); chk("R9 edge after 2 edges", v, 32'h0);
        @(negedge clk); rd(3'd5, v); chk("R9 edge after 3 edges", v, 32'h1);

        // ---------------- R6 clear sequence ----------------
        do_reset();
        wr(3'd0, 32'hFFFF_FFFF); wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
        line = 32'h1; settle();
        chk("R6 irq set", {31'b0, irq}, 32'h1);
        wr(3'd4, 32'h1);
        rd(3'd5, v); chk("R6 clear 0->1", v, 32'h0);
        chk("R6 irq cleared", {31'b0, irq}, 32'h0);
        line = 32'h0; settle();
        line = 32'h1; settle();
        rd(3'd5, v); chk("R6 relatched", v, 32'h1);
        wr(3'd4, 32'h1);
        rd(3'd5, v); chk("R6 1 over 1 keeps", v, 32'h1);
        wr(3'd4, 32'h0);
        rd(3'd5, v); chk("R6 write 0 keeps", v, 32'h1);
        wr(3'd4, 32'h1);
        rd(3'd5, v); chk("R6 second clear", v, 32'h0);

        // ---------------- R7 clear meets edge ----------------
        do_reset();
        wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
        line = 32'h1;
        @(posedge clk); @(posedge clk);
        wr(3'd4, 32'h1);
        rd(3'd5, v); chk("R7 new edge kept", v, 32'h1);
        wr(3'd4, 32'h0);
        line = 32'h0;
        @(posedge clk); @(posedge clk);
        wr(3'd4, 32'h1);
        rd(3'd5, v); chk("R7 latched edge cleared", v, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule